// File: doc/BRIEF.md
# Multi-Phase Dithered Digital Pulse-Width Modulator

This block is a counter-comparator pulse-width modulator for a four-phase buck converter. It has a coarse hardware duty resolution of 7 bits. Three dither bits refine that resolution to an effective 10 bits. The 10-bit duty word splits into two parts. The upper 7 bits give a base level. The lower 3 bits say how many of every 8 switching periods run one count higher than that base level. The output filter averages these periods to a level between two hardware steps.

One shared period counter drives all four phases. Each phase is offset by a quarter period. Each phase picks its level for a period at the start of its own period, using its own position in the 8-period dither pattern. In one period the phases use different adjacent levels. They take turns on the upper level, so every phase ends up with the same average. A new duty word is taken only when a dither pattern ends, so a pattern is never cut short. Gate drivers and dead time are handled outside this block.

Top module: `dpwm_multiphase_dither`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is low after that edge, and the shared counter, pattern index and active duty restart from zero.
- R2: A switching period is 128 clocks. Phase k's own period starts when the shared counter equals 32*k. The output is registered: one clock after the counter shows phase offset p (counter minus 32*k, mod 128), phase k is high exactly when p is below that phase's level L for the period.
- R3: The level L that phase k picks at the start of its period is hi + u. Here hi = duty[9:3]. u is 1 when the bit-reversed 3-bit index q is below duty[2:0], with q = (shared pattern index + k) mod 8. The shared pattern index counts shared periods mod 8. L is held for the whole period.
- R4: Over the 8 own periods of phase k that start inside one pattern, the phase is high for 8*hi + duty[2:0] clocks in total.
- R5: With duty[2:0] = 4, phase 0 switches between hi+1 and hi on every period, starting with hi+1 at pattern index 0.
- R6: With duty[2:0] = 2, phase 0 uses the upper level at pattern indices 0 and 4 only, so the upper periods are four periods apart.
- R7: With duty[2:0] = 4, phases 0 and 1 use different levels in the same shared period, and they swap those levels in the next period.
- R8: The duty input is copied into the active duty only on the clock where the counter is 127 and the pattern index is 7. A value that is on the input at any other clock has no effect on the outputs.
- R9: A duty of 0 keeps every output low.
- R10: A duty of all ones (1023) sets L = 128 in every period, so every output stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_in | input | 10 | Requested duty: hardware level in [9:3], dither count in [2:0] |
| pwm_out | output | 4 | Phase gate commands; bit k is phase k |

## Verification
Each output bit comes one register after the shared counter. The bench therefore treats the value it sees at the falling edge after rising edge n as the design state at time n-1, and checks every phase on every clock against a model built from R2 and R3. The duty input takes effect at the first clock of the next pattern, 1024 clocks after a pattern starts. So the model switches its active duty only at those clocks. The bench also changes the input in the middle of a pattern to show that those changes are ignored. The per-period and pattern totals for a phase can only be checked once that phase's eighth period has ended, and phase 3 ends 96 clocks into the next pattern. So each pattern is judged 200 clocks into the pattern that follows it.

// File: rtl/dpwm_pkg.sv
// Package: default sizing shared by the dithered PWM modules.
// Assumes the phase count divides the counter range evenly.
package dpwm_pkg;
    localparam int DPWM_HW_BITS   = 7;  // coarse counter resolution
    localparam int DPWM_DITH_BITS = 3;  // dither refinement bits
    localparam int DPWM_PHASES    = 4;  // staggered output phases
endpackage

// File: rtl/dpwm_timebase.sv
// Module: shared period counter, dither pattern index and duty latch.
// Assumes duty_in is synchronous to clk; it is sampled only at the end
// of a full dither pattern.
module dpwm_timebase #(
    parameter int HW_BITS   = dpwm_pkg::DPWM_HW_BITS,
    parameter int DITH_BITS = dpwm_pkg::DPWM_DITH_BITS,
    localparam int DUTY_W   = HW_BITS + DITH_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DUTY_W-1:0]    duty_in,
    output logic [HW_BITS-1:0]   cnt_o,
    output logic [DITH_BITS-1:0] pidx_o,
    output logic [DUTY_W-1:0]    duty_act_o
);
    localparam logic [HW_BITS-1:0]   CNT_LAST  = {HW_BITS{1'b1}};
    localparam logic [DITH_BITS-1:0] PIDX_LAST = {DITH_BITS{1'b1}};

    logic [HW_BITS-1:0]   cnt_q;
    logic [DITH_BITS-1:0] pidx_q;
    logic [DUTY_W-1:0]    duty_q;
    logic                 period_end;
    logic                 pattern_end;

    assign period_end  = (cnt_q == CNT_LAST);
    assign pattern_end = period_end && (pidx_q == PIDX_LAST);

    // Free-running period counter, wraps every 2^HW_BITS clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Pattern index advances once per shared switching period.
    always_ff @(posedge clk) begin
        if (!rst_n)          pidx_q <= '0;
        else if (period_end) pidx_q <= pidx_q + 1'b1;
    end

    // Active duty reloads only when a dither pattern completes.
    always_ff @(posedge clk) begin
        if (!rst_n)           duty_q <= '0;
        else if (pattern_end) duty_q <= duty_in;
    end

    assign cnt_o      = cnt_q;
    assign pidx_o     = pidx_q;
    assign duty_act_o = duty_q;

    AST_PIDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(pidx_q)) else $error("pattern index moved mid-period"); // R2
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pattern_end |=> $stable(duty_q)) else $error("duty reloaded mid-pattern"); // R8
endmodule

// File: rtl/dpwm_level_sel.sv
// Module: picks the hardware level for one period from the active duty
// and a pattern index. The upper level is used when the bit-reversed
// index is below the dither count, which spreads upper periods evenly.
// An all-ones duty saturates to a level that is high for the whole period.
module dpwm_level_sel #(
    parameter int HW_BITS   = dpwm_pkg::DPWM_HW_BITS,
    parameter int DITH_BITS = dpwm_pkg::DPWM_DITH_BITS,
    localparam int DUTY_W   = HW_BITS + DITH_BITS,
    localparam int LVL_W    = HW_BITS + 1
) (
    input  logic [DUTY_W-1:0]    duty,
    input  logic [DITH_BITS-1:0] idx,
    output logic [LVL_W-1:0]     level
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(1) << HW_BITS;

    logic [DITH_BITS-1:0] idx_rev;
    logic [HW_BITS-1:0]   base;
    logic [DITH_BITS-1:0] frac;
    logic                 upper;
    logic                 full;

    // Bit reversal of the pattern index, one wire per bit.
    for (genvar i = 0; i < DITH_BITS; i++) begin : g_rev
        assign idx_rev[i] = idx[DITH_BITS-1-i];
    end

    assign base  = duty[DUTY_W-1:DITH_BITS];
    assign frac  = duty[DITH_BITS-1:0];
    assign full  = &duty;
    assign upper = (idx_rev < frac);

    // Level is base or base+1, or saturated for an all-ones duty.
    always_comb begin
        if (full) level = LVL_FULL;
        else      level = {1'b0, base} + LVL_W'(upper);
    end
endmodule

// File: rtl/dpwm_phase.sv
// Module: one staggered phase. Its period starts when the shared counter
// equals OFFSET. The level is captured at that start and held, and the
// output is a registered compare of the phase-local count against it.
module dpwm_phase #(
    parameter int HW_BITS = dpwm_pkg::DPWM_HW_BITS,
    parameter int OFFSET  = 0,
    localparam int LVL_W  = HW_BITS + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HW_BITS-1:0] cnt,
    input  logic [LVL_W-1:0]   sel_level,
    output logic               pwm
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(1) << HW_BITS;

    logic [HW_BITS-1:0] ph;
    logic               start;
    logic [LVL_W-1:0]   lvl_q;
    logic [LVL_W-1:0]   lvl_use;
    logic               pwm_q;

    assign ph      = cnt - HW_BITS'(OFFSET);
    assign start   = (ph == '0);
    assign lvl_use = start ? sel_level : lvl_q;

    // Hold the level chosen at the start of this phase's period.
    always_ff @(posedge clk) begin
        if (!rst_n)     lvl_q <= '0;
        else if (start) lvl_q <= sel_level;
    end

    // Registered compare so the gate command is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= ({1'b0, ph} < lvl_use);
    end

    assign pwm = pwm_q;

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(lvl_q)) else $error("level changed inside a period"); // R3
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && lvl_q == '0) |=> !pwm_q) else $error("output high at zero level"); // R9
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && lvl_q == LVL_FULL) |=> pwm_q) else $error("output low at full level"); // R10
endmodule

// File: rtl/dpwm_multiphase_dither.sv
// Module: top of the multi-phase dithered PWM. One timebase feeds
// PHASES level selectors and phase comparators. Phase k is offset by
// k/PHASES of a period and by k steps in the dither pattern, so that the
// phases share out the upper level within each period.
module dpwm_multiphase_dither #(
    parameter int HW_BITS   = dpwm_pkg::DPWM_HW_BITS,
    parameter int DITH_BITS = dpwm_pkg::DPWM_DITH_BITS,
    parameter int PHASES    = dpwm_pkg::DPWM_PHASES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [HW_BITS+DITH_BITS-1:0]   duty_in,
    output logic [PHASES-1:0]              pwm_out
);
    localparam int DUTY_W  = HW_BITS + DITH_BITS;
    localparam int LVL_W   = HW_BITS + 1;
    localparam int PH_STEP = (1 << HW_BITS) / PHASES;
    localparam int NUM_PAT = 1 << DITH_BITS;

    logic [HW_BITS-1:0]   cnt;
    logic [DITH_BITS-1:0] pidx;
    logic [DUTY_W-1:0]    duty_act;

    dpwm_timebase #(.HW_BITS(HW_BITS), .DITH_BITS(DITH_BITS)) u_tb (
        .clk(clk), .rst_n(rst_n), .duty_in(duty_in),
        .cnt_o(cnt), .pidx_o(pidx), .duty_act_o(duty_act)
    );

    // One selector and one comparator per staggered phase.
    for (genvar k = 0; k < PHASES; k++) begin : g_phase
        logic [DITH_BITS-1:0] idx_k;
        logic [LVL_W-1:0]     lvl_k;

        assign idx_k = pidx + DITH_BITS'(k % NUM_PAT);

        dpwm_level_sel #(.HW_BITS(HW_BITS), .DITH_BITS(DITH_BITS)) u_sel (
            .duty(duty_act), .idx(idx_k), .level(lvl_k)
        );

        dpwm_phase #(.HW_BITS(HW_BITS), .OFFSET(k * PH_STEP)) u_ph (
            .clk(clk), .rst_n(rst_n), .cnt(cnt),
            .sel_level(lvl_k), .pwm(pwm_out[k])
        );
    end
endmodule

// File: tb/dpwm_multiphase_dither_tb.sv
// Bench: runs a sequence of duty words, one per dither pattern, and
// compares every phase on every clock with an arithmetic model. After
// each pattern it checks the per-period and total high counts.
module dpwm_multiphase_dither_tb;
    localparam int PER  = 128;
    localparam int BLK  = 1024;
    localparam int STEP = 32;
    localparam int NBLK = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] duty_in = '0;
    wire  [3:0] pwm;

    int checks = 0;
    int errors = 0;
    logic [9:0] act = '0;
    logic [9:0] prev_act = '0;
    int pc [4][64];
    int tgt [0:11];

    always #4 clk = ~clk;

    dpwm_multiphase_dither u_dut (
        .clk(clk), .rst_n(rst_n), .duty_in(duty_in), .pwm_out(pwm)
    );

    function automatic int sel_f(int d, int q);
        logic [2:0] qq;
        logic [2:0] rv;
        if (d == 1023) return 128;
        qq = 3'(q);
        rv = {qq[0], qq[1], qq[2]};
        return (d >> 3) + ((int'(rv) < (d & 7)) ? 1 : 0);
    endfunction

    function automatic logic exp_out(int k, int s);
        int c, ph, s0, d;
        c  = s % PER;
        ph = (c - STEP * k + PER) % PER;
        s0 = s - ph;
        if (s0 < 0) return 1'b0;
        d = ((s0 / BLK) == (s / BLK)) ? int'(act) : int'(prev_act);
        return (ph < sel_f(d, (s0 / PER) + k)) ? 1'b1 : 1'b0;
    endfunction

    task automatic chk(input string req, input int actual, input int expv);
        checks++;
        if (actual != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expv);
        end
    endtask

    task automatic check_block(input int b);
        int d, hi, lo, base, sum;
        d = tgt[b]; hi = d >> 3; lo = d & 7; base = 8 * b;
        for (int k = 0; k < 4; k++) begin
            sum = 0;
            for (int j = 0; j < 8; j++) begin
                sum += pc[k][(base + j) % 64];
                chk("R3 period level", pc[k][(base + j) % 64], sel_f(d, j + k));
            end
            if (d == 0)         chk("R9 zero duty total", sum, 0);
            else if (d == 1023) chk("R10 full duty total", sum, 8 * PER);
            else                chk("R4 pattern total", sum, 8 * hi + lo);
            chk("R8 ignores mid-pattern input", sum, (d == 1023) ? 8 * PER : 8 * hi + lo);
        end
        if (lo == 4 && d != 1023) begin
            for (int j = 0; j < 8; j++)
                chk("R5 half step alternation", pc[0][(base + j) % 64], hi + ((j % 2 == 0) ? 1 : 0));
            for (int j = 0; j < 7; j++) begin
                chk("R7 phases differ", (pc[0][(base + j) % 64] != pc[1][(base + j) % 64]) ? 1 : 0, 1);
                chk("R7 levels swap", pc[0][(base + j) % 64], pc[1][(base + j + 1) % 64]);
            end
        end
        if (lo == 2) begin
            chk("R6 upper at index 0", pc[0][base % 64], hi + 1);
            chk("R6 upper at index 4", pc[0][(base + 4) % 64], hi + 1);
            chk("R6 lower at index 2", pc[0][(base + 2) % 64], hi);
            chk("R6 lower at index 6", pc[0][(base + 6) % 64], hi);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tgt[0] = 0;    tgt[1] = 36;   tgt[2] = 402;  tgt[3] = 0;
        tgt[4] = 1023; tgt[5] = 83;   tgt[6] = 807;  tgt[7] = 1022;
        tgt[8] = 8;    tgt[9] = 5;    tgt[10] = 700; tgt[11] = 0;
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 64; j++) pc[k][j] = 0;
        duty_in = 10'h3FF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 outputs low in reset", int'(pwm), 0);
        duty_in = 10'd36;
        rst_n = 1'b1;
        for (int n = 1; n <= NBLK * BLK; n++) begin
            int s, b, r;
            @(posedge clk);
            @(negedge clk);
            s = n - 1;
            for (int k = 0; k < 4; k++) begin
                chk(s < PER ? "R1 restart waveform" : "R2 phase waveform",
                    int'(pwm[k]), int'(exp_out(k, s)));
                if (s >= STEP * k) begin
                    int t;
                    t = s - STEP * k;
                    if (t % PER == 0) pc[k][(t / PER) % 64] = 0;
                    pc[k][(t / PER) % 64] += int'(pwm[k]);
                end
            end
            if (n % BLK == 0) begin
                prev_act = act;
                act = duty_in;
            end
            b = n / BLK;
            r = n % BLK;
            if (r == 200 && b >= 2) check_block(b - 1);
            if (b + 1 <= 11) begin
                if (r == 300) duty_in = 10'(tgt[b + 1] ^ 'h2A5);
                if (r == 700) duty_in = 10'(tgt[b + 1]);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule